// File: doc/BRIEF.md
# Object-Granular Recency Cache Index

This block is the on-chip directory of a packet cache that stores objects as unbroken runs of packets starting from packet 1. Every tracked object owns one slot in a small fully associative table. A slot holds the object key, the number of the highest packet stored without a gap, and the store address of that packet. A lookup for packet p of an object is decided from the table alone. The request hits when the object is present and p lies in 1..last. On a hit the block returns the tail address and the number of backward steps (last - p) that the external store must walk.

Insert requests carry the store address where the new packet would be written. Only packet 1 may open a new object. A present object only grows by exactly one packet at a time. Recency is kept per object, and a lookup hit or an admitted insert makes that object the most recent. When a new object needs a slot and the table is full, the least recent object is dropped whole and a command tells the store manager to free it. When the store runs out of room, the store manager issues a trim request. The block then picks the least recent object, commands the release of its tail packet, and shrinks the entry. While the store manager looks up the predecessor address of that packet, the block stalls, and it takes the new tail address on a separate link input.

Top module: `obj_lru_index`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and cmd_valid are 0, and every lookup misses.
- R2: A lookup (req_op 0) hits only if req_key is present and 1 <= req_pkt <= last. On a hit, resp_ptr is the tail address and resp_steps is last - req_pkt. On a miss, resp_hit, resp_ptr and resp_steps are 0.
- R3: An insert (req_op 1) for an absent key creates an entry only when req_pkt is 1. Any other packet number is dropped with resp_hit 0 and no command, and a later lookup of that key misses.
- R4: An insert for a present key is admitted only when req_pkt equals last + 1. Otherwise it is dropped and the entry is unchanged.
- R5: An admitted insert sets last to req_pkt and the tail address to req_ptr. It responds with resp_hit 1, resp_ptr = req_ptr and resp_steps 0.
- R6: A lookup hit or an admitted insert makes the object the most recently used.
- R7: An insert of packet 1 for a new key while all ENTRIES slots are valid evicts the least recently used object. It issues cmd_op 1 (free whole object) with that object's key, tail address and packet count in cmd_count, in the same cycle as the response.
- R8: A trim (req_op 2) on a non-empty index picks the least recently used object and issues cmd_op 2 (free packet) with its key, tail address and cmd_count = old last, with resp_hit 1. The last field drops by one. If the count reaches 0, the entry is freed and later lookups of that key miss.
- R9: After a trim that leaves packets in the object, req_ready stays 0 until link_valid is seen. link_ptr then becomes that object's tail address.
- R10: A trim on an empty index responds with resp_hit 0 and no command.
- R11: Each accepted request (req_valid and req_ready at a clock edge) produces exactly one resp_valid pulse in the following cycle, and resp_valid is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 lookup, 1 insert, 2 trim |
| req_key | input | KEY_W | Object key |
| req_pkt | input | PKT_W | Packet number (starts at 1) |
| req_ptr | input | PTR_W | Store address of the packet offered by an insert |
| link_valid | input | 1 | Predecessor address is available after a trim |
| link_ptr | input | PTR_W | New tail address after a trim |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Lookup hit, insert admitted, or trim performed |
| resp_ptr | output | PTR_W | Tail address on a lookup hit, or the admitted packet's address |
| resp_steps | output | PKT_W | Backward steps from the tail to the requested packet |
| cmd_valid | output | 1 | Store command pulse |
| cmd_op | output | 2 | 0 none, 1 free whole object, 2 free tail packet |
| cmd_key | output | KEY_W | Key of the object the command concerns |
| cmd_ptr | output | PTR_W | Tail address of that object |
| cmd_count | output | PKT_W | Packet count of that object before the command |

## Verification
Two functions meet in one insert: a new object is placed and the least recent object is evicted, and the evicted object's slot is reused by the new one. The bench fills all sixteen slots, then refreshes the oldest object with a lookup so that the second oldest becomes the victim. It then inserts packet 1 of a fresh key. It judges the response and the free-object command of that single cycle against a queue-based recency model, and then confirms that the refreshed object still hits and the victim misses. A long pseudo-random mix of lookups, inserts and trims over more keys than slots repeats this collision many times, and every response and command is compared with the model.

// File: rtl/oli_pkg.sv
package oli_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_TRIM   = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_FREE_OBJ = 2'd1,
        CMD_FREE_PKT = 2'd2
    } cmd_e;
endpackage

// File: rtl/oli_match.sv
module oli_match #(
    parameter int N     = 16,
    parameter int KEY_W = 16,
    parameter int IW    = 4
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]        key,
    output logic                    hit,
    output logic [IW-1:0]           hit_idx,
    output logic [IW-1:0]           free_idx,
    output logic                    full
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = vld[g] && (keys[g] == key);
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i])   hit_idx  = IW'(i);
            if (!vld[i]) free_idx = IW'(i);
        end
    end

    assign hit  = |eq;
    assign full = &vld;
endmodule

// File: rtl/oli_rank.sv
module oli_rank #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vld,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic          free_en,
    input  logic [IW-1:0] free_idx,
    output logic          victim_found,
    output logic [IW-1:0] victim_idx
);
    logic [N-1:0][IW-1:0] rank_d, rank_q;

    always_comb begin
        rank_d = rank_q;
        if (touch_en) begin
            for (int j = 0; j < N; j++) begin
                if (IW'(j) == touch_idx)               rank_d[j] = '0;
                else if (rank_q[j] < rank_q[touch_idx]) rank_d[j] = rank_q[j] + 1'b1;
            end
        end else if (free_en) begin
            for (int j = 0; j < N; j++) begin
                if (IW'(j) == free_idx)                rank_d[j] = IW'(N - 1);
                else if (rank_q[j] > rank_q[free_idx])  rank_d[j] = rank_q[j] - 1'b1;
            end
        end
    end

    always_comb begin
        victim_found = 1'b0;
        victim_idx   = '0;
        for (int j = 0; j < N; j++) begin
            if (vld[j] && (!victim_found || rank_q[j] > rank_q[victim_idx])) begin
                victim_found = 1'b1;
                victim_idx   = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) rank_q[j] <= IW'(j);
        end else begin
            rank_q <= rank_d;
        end
    end
endmodule

// File: rtl/obj_lru_index.sv
module obj_lru_index
    import oli_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 16,
    parameter int PKT_W   = 16,
    parameter int PTR_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [KEY_W-1:0] req_key,
    input  logic [PKT_W-1:0] req_pkt,
    input  logic [PTR_W-1:0] req_ptr,
    input  logic             link_valid,
    input  logic [PTR_W-1:0] link_ptr,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [PTR_W-1:0] resp_ptr,
    output logic [PKT_W-1:0] resp_steps,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [KEY_W-1:0] cmd_key,
    output logic [PTR_W-1:0] cmd_ptr,
    output logic [PKT_W-1:0] cmd_count
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][KEY_W-1:0] key;
        logic [ENTRIES-1:0][PKT_W-1:0] last;
        logic [ENTRIES-1:0][PTR_W-1:0] ptr;
        logic                          busy;
        logic [IW-1:0]                 widx;
        logic                          rsp_v;
        logic                          rsp_hit;
        logic [PTR_W-1:0]              rsp_ptr;
        logic [PKT_W-1:0]              rsp_steps;
        logic                          cmd_v;
        logic [1:0]                    cmd_op;
        logic [KEY_W-1:0]              cmd_key;
        logic [PTR_W-1:0]              cmd_ptr;
        logic [PKT_W-1:0]              cmd_cnt;
    } state_t;

    state_t st_d, st_q;

    logic          m_hit, m_full;
    logic [IW-1:0] m_idx, m_free;
    logic          v_found;
    logic [IW-1:0] v_idx;
    logic          touch_en, free_en;
    logic [IW-1:0] touch_idx, free_idx;
    logic          accept;

    oli_match #(.N(ENTRIES), .KEY_W(KEY_W), .IW(IW)) u_match (
        .vld      (st_q.vld),
        .keys     (st_q.key),
        .key      (req_key),
        .hit      (m_hit),
        .hit_idx  (m_idx),
        .free_idx (m_free),
        .full     (m_full)
    );

    oli_rank #(.N(ENTRIES), .IW(IW)) u_rank (
        .clk          (clk),
        .rst_n        (rst_n),
        .vld          (st_q.vld),
        .touch_en     (touch_en),
        .touch_idx    (touch_idx),
        .free_en      (free_en),
        .free_idx     (free_idx),
        .victim_found (v_found),
        .victim_idx   (v_idx)
    );

    assign req_ready = !st_q.busy;
    assign accept    = req_valid && req_ready;

    always_comb begin
        logic [IW-1:0] slot;
        st_d           = st_q;
        st_d.rsp_v     = 1'b0;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_ptr   = '0;
        st_d.rsp_steps = '0;
        st_d.cmd_v     = 1'b0;
        st_d.cmd_op    = CMD_NONE;
        st_d.cmd_key   = '0;
        st_d.cmd_ptr   = '0;
        st_d.cmd_cnt   = '0;
        touch_en       = 1'b0;
        touch_idx      = '0;
        free_en        = 1'b0;
        free_idx       = '0;
        slot           = m_full ? v_idx : m_free;

        if (st_q.busy && link_valid) begin
            st_d.ptr[st_q.widx] = link_ptr;
            st_d.busy           = 1'b0;
        end

        if (accept) begin
            st_d.rsp_v = 1'b1;
            case (req_op)
                OP_LOOKUP: begin
                    if (m_hit && req_pkt != '0 && req_pkt <= st_q.last[m_idx]) begin
                        st_d.rsp_hit   = 1'b1;
                        st_d.rsp_ptr   = st_q.ptr[m_idx];
                        st_d.rsp_steps = st_q.last[m_idx] - req_pkt;
                        touch_en       = 1'b1;
                        touch_idx      = m_idx;
                    end
                end
                OP_INSERT: begin
                    if (m_hit) begin
                        if (req_pkt != '0 && (req_pkt - PKT_W'(1)) == st_q.last[m_idx]) begin
                            st_d.last[m_idx] = req_pkt;
                            st_d.ptr[m_idx]  = req_ptr;
                            st_d.rsp_hit     = 1'b1;
                            st_d.rsp_ptr     = req_ptr;
                            touch_en         = 1'b1;
                            touch_idx        = m_idx;
                        end
                    end else if (req_pkt == PKT_W'(1)) begin
                        if (m_full) begin
                            st_d.cmd_v   = 1'b1;
                            st_d.cmd_op  = CMD_FREE_OBJ;
                            st_d.cmd_key = st_q.key[slot];
                            st_d.cmd_ptr = st_q.ptr[slot];
                            st_d.cmd_cnt = st_q.last[slot];
                        end
                        st_d.vld[slot]  = 1'b1;
                        st_d.key[slot]  = req_key;
                        st_d.last[slot] = PKT_W'(1);
                        st_d.ptr[slot]  = req_ptr;
                        st_d.rsp_hit    = 1'b1;
                        st_d.rsp_ptr    = req_ptr;
                        touch_en        = 1'b1;
                        touch_idx       = slot;
                    end
                end
                OP_TRIM: begin
                    if (v_found) begin
                        st_d.cmd_v   = 1'b1;
                        st_d.cmd_op  = CMD_FREE_PKT;
                        st_d.cmd_key = st_q.key[v_idx];
                        st_d.cmd_ptr = st_q.ptr[v_idx];
                        st_d.cmd_cnt = st_q.last[v_idx];
                        st_d.rsp_hit = 1'b1;
                        if (st_q.last[v_idx] == PKT_W'(1)) begin
                            st_d.vld[v_idx]  = 1'b0;
                            st_d.last[v_idx] = '0;
                            st_d.ptr[v_idx]  = '0;
                            free_en          = 1'b1;
                            free_idx         = v_idx;
                        end else begin
                            st_d.last[v_idx] = st_q.last[v_idx] - PKT_W'(1);
                            st_d.busy        = 1'b1;
                            st_d.widx        = v_idx;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid = st_q.rsp_v;
    assign resp_hit   = st_q.rsp_hit;
    assign resp_ptr   = st_q.rsp_ptr;
    assign resp_steps = st_q.rsp_steps;
    assign cmd_valid  = st_q.cmd_v;
    assign cmd_op     = st_q.cmd_op;
    assign cmd_key    = st_q.cmd_key;
    assign cmd_ptr    = st_q.cmd_ptr;
    assign cmd_count  = st_q.cmd_cnt;
endmodule

// File: rtl/obj_lru_index_chk.sv
module obj_lru_index_chk
    import oli_pkg::*;
#(
    parameter int PKT_W = 16,
    parameter int PTR_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic [PKT_W-1:0] req_pkt,
    input logic [PTR_W-1:0] req_ptr,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic [PTR_W-1:0] resp_ptr,
    input logic [PKT_W-1:0] resp_steps,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [PKT_W-1:0] cmd_count
);
    a_r11_one_resp_per_accept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (resp_valid == $past(req_valid && req_ready)));

    a_r2_miss_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_ptr == '0 && resp_steps == '0));

    a_r5_admit_echoes_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == OP_INSERT) |=>
            (!resp_hit || (resp_ptr == $past(req_ptr) && resp_steps == '0)));

    a_r7_obj_free_from_new_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_op == OP_INSERT && req_pkt == PKT_W'(1))) |=>
            !(cmd_valid && cmd_op == CMD_FREE_OBJ));

    a_r9_stall_until_link: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_FREE_PKT && cmd_count > PKT_W'(1)) |-> !req_ready);

    a_r8_cmd_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_count != '0 && resp_valid));
endmodule

bind obj_lru_index obj_lru_index_chk #(.PKT_W(PKT_W), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_pkt    (req_pkt),
    .req_ptr    (req_ptr),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_ptr   (resp_ptr),
    .resp_steps (resp_steps),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_count  (cmd_count)
);

// File: tb/obj_lru_index_bench.sv
`timescale 1ns/1ps
module obj_lru_index_bench;
    localparam int N     = 16;
    localparam int KEY_W = 16;
    localparam int PKT_W = 16;
    localparam int PTR_W = 20;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = '0;
    logic [KEY_W-1:0] req_key = '0;
    logic [PKT_W-1:0] req_pkt = '0;
    logic [PTR_W-1:0] req_ptr = '0;
    logic             link_valid = 1'b0;
    logic [PTR_W-1:0] link_ptr = '0;
    logic             resp_valid, resp_hit;
    logic [PTR_W-1:0] resp_ptr;
    logic [PKT_W-1:0] resp_steps;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [KEY_W-1:0] cmd_key;
    logic [PTR_W-1:0] cmd_ptr;
    logic [PKT_W-1:0] cmd_count;

    int errors = 0;
    int checks = 0;
    int link_ctr = 5000;

    // recency model: front of the queue is the most recent object
    int lru[$];
    int m_last[int];
    int m_ptr[int];

    always #2 clk = ~clk;

    obj_lru_index #(.ENTRIES(N), .KEY_W(KEY_W), .PKT_W(PKT_W), .PTR_W(PTR_W)) u_obj_lru_index (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_key(req_key), .req_pkt(req_pkt), .req_ptr(req_ptr),
        .link_valid(link_valid), .link_ptr(link_ptr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_ptr(resp_ptr),
        .resp_steps(resp_steps), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_key(cmd_key), .cmd_ptr(cmd_ptr), .cmd_count(cmd_count)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int find(int k);
        foreach (lru[i]) if (lru[i] == k) return i;
        return -1;
    endfunction

    function automatic void touch(int k);
        int pos = find(k);
        lru.delete(pos);
        lru.push_front(k);
    endfunction

    task automatic do_req(input int op, input int k, input int p, input int ptr);
        bit e_hit = 0, e_cv = 0, e_wait = 0;
        int e_ptr = 0, e_steps = 0, e_cop = 0, e_ckey = 0, e_cptr = 0, e_ccnt = 0;
        int pos = find(k);
        int v;
        case (op)
            0: if (pos >= 0 && p >= 1 && p <= m_last[k]) begin
                e_hit = 1; e_ptr = m_ptr[k]; e_steps = m_last[k] - p; touch(k);
            end
            1: if (pos >= 0) begin
                if (p == m_last[k] + 1) begin
                    e_hit = 1; e_ptr = ptr; m_last[k] = p; m_ptr[k] = ptr; touch(k);
                end
            end else if (p == 1) begin
                if (lru.size() == N) begin
                    v = lru.pop_back();
                    e_cv = 1; e_cop = 1; e_ckey = v; e_cptr = m_ptr[v]; e_ccnt = m_last[v];
                    m_last.delete(v); m_ptr.delete(v);
                end
                lru.push_front(k); m_last[k] = 1; m_ptr[k] = ptr;
                e_hit = 1; e_ptr = ptr;
            end
            2: if (lru.size() > 0) begin
                v = lru[lru.size()-1];
                e_cv = 1; e_cop = 2; e_ckey = v; e_cptr = m_ptr[v]; e_ccnt = m_last[v];
                e_hit = 1;
                if (m_last[v] == 1) begin
                    void'(lru.pop_back()); m_last.delete(v); m_ptr.delete(v);
                end else begin
                    m_last[v] = m_last[v] - 1; e_wait = 1; k = v;
                end
            end
            default: ;
        endcase
        chk("R11 ready before request", req_ready, 1);
        req_valid = 1'b1; req_op = 2'(op); req_key = KEY_W'(k); req_pkt = PKT_W'(p); req_ptr = PTR_W'(ptr);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 resp_valid", resp_valid, 1);
        chk(op == 2 ? "R8/R10 resp_hit" : (op == 1 ? "R3/R4 resp_hit" : "R2 resp_hit"), resp_hit, e_hit);
        chk("R2/R5 resp_ptr", resp_ptr, e_ptr);
        chk("R2 resp_steps", resp_steps, e_steps);
        chk("R7/R8 cmd_valid", cmd_valid, e_cv);
        if (e_cv) begin
            chk("R7/R8 cmd_op", cmd_op, e_cop);
            chk("R7/R8 cmd_key", cmd_key, e_ckey);
            chk("R7/R8 cmd_ptr", cmd_ptr, e_cptr);
            chk("R7/R8 cmd_count", cmd_count, e_ccnt);
        end
        if (e_wait) begin
            chk("R9 ready low while waiting", req_ready, 0);
            @(posedge clk); @(negedge clk);
            chk("R9 still stalled", req_ready, 0);
            chk("R11 no resp while stalled", resp_valid, 0);
            link_ctr++;
            link_valid = 1'b1; link_ptr = PTR_W'(link_ctr); m_ptr[k] = link_ctr;
            @(posedge clk); @(negedge clk);
            link_valid = 1'b0;
            chk("R9 ready after link", req_ready, 1);
        end
        @(posedge clk); @(negedge clk);
        chk("R11 single resp pulse", resp_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nptr = 100;
        int lcg = 12345;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 resp_valid after reset", resp_valid, 0);
        chk("R1 cmd_valid after reset", cmd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(0, 5, 1, 0);                 // R1 empty index misses
        do_req(1, 10, 2, 90);               // R3 non-first packet dropped
        do_req(0, 10, 2, 0);                // R3 still absent
        do_req(1, 10, 1, 100);              // R3/R5 open object
        do_req(1, 10, 3, 91);               // R4 gap dropped
        do_req(1, 10, 1, 92);               // R4 repeat of packet 1 dropped
        do_req(1, 10, 2, 101);              // R5 contiguous growth
        do_req(0, 10, 1, 0);                // R2 hit, one step back
        do_req(0, 10, 2, 0);                // R2 hit at tail
        do_req(0, 10, 3, 0);                // R2 beyond last misses
        do_req(0, 10, 0, 0);                // R2 packet 0 misses
        for (int i = 0; i < N - 1; i++) do_req(1, 20 + i, 1, 200 + i);
        do_req(0, 10, 1, 0);                // R6 refresh oldest
        do_req(1, 40, 1, 300);              // R7 evicts key 20, not 10
        chk("R7 victim key is 20", 20, (find(20) < 0) ? 20 : -1);
        do_req(0, 20, 1, 0);                // R7 victim gone
        do_req(0, 10, 2, 0);                // R6 refreshed object kept
        while (lru.size() > 0) do_req(2, 0, 0, 0); // R8/R9 drain
        do_req(2, 0, 0, 0);                 // R10 empty trim
        do_req(0, 10, 1, 0);                // R8 freed entries miss
        for (int i = 0; i < 600; i++) begin
            int r, op;
            lcg = lcg * 1103515245 + 12345;
            r = (lcg >>> 8) & 32'h7fffff;
            op = (r % 10 < 5) ? 1 : ((r % 10 < 8) ? 0 : 2);
            nptr++;
            do_req(op, 100 + (r / 10) % 20, (r / 200) % 5, nptr);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule